// File: doc/BRIEF.md
# Serial Two-Wire Register Pointer Target

This block is the target side of an I2C bus. It gives a bus master byte access to a small register array, 32 entries at default parameters. A fast system clock oversamples the SCL and SDA lines. From those samples the block recognises bus START, repeated START and STOP conditions, and it shifts bytes in and out one bit per SCL cycle. SDA is never driven high. The block pulls the line low only by raising an output enable. SDA is released after reset and whenever the block has nothing to say.

A transaction opens with a START and an identifier byte. The upper seven bits of that byte must match the device identifier, and its lowest bit sets the direction (1 = read, 0 = write). In the write direction, the next byte loads an internal address pointer, and each byte after it is stored at the pointer, which then steps by one. In the read direction, the block returns bytes starting at the pointer and steps the pointer after each one. It keeps going for as long as the master acknowledges.

The pointer survives between transactions. A read with no address byte therefore continues where the last access stopped. A random read is built from a write-direction identifier and an address byte, followed by a repeated START and a read-direction identifier. The register array sits behind a plain synchronous port. The pointer is always presented as the address. A write strobe lasts one system clock. Read data is expected one system clock after the address.

Top module: `i2c_regptr_target`

## Requirements
- R1: While reset is held and right after it, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: After START, an identifier byte 0xDE (device bits 1101111, direction bit 0) and an address byte are each acknowledged by pulling SDA low on the ninth SCL clock. A following data byte is acknowledged and written through a single `reg_we` pulse, with `reg_addr` equal to the address byte.
- R3: Every data byte of a write is stored at the pointer, and the pointer then steps by one. Stepping from 0x1F goes to 0x00.
- R4: An identifier whose upper seven bits differ from 1101111 gets no acknowledge. Nothing is written and SDA stays released until the next START.
- R5: A random read (0xDE, address, repeated START, 0xDF) returns the byte stored at that address. The byte is sent most significant bit first, with each bit valid while SCL is high.
- R6: During a read, the pointer steps by one after each byte sent and wraps from 0x1F to 0x00. The block keeps sending for every acknowledge from the master.
- R7: After the master leaves a read byte unacknowledged, the block keeps SDA released through any further SCL clocks until a STOP or START.
- R8: The pointer keeps its value across a STOP. A read that opens directly with 0xDF starts at the current pointer.
- R9: Only the low five bits of the address byte load the pointer. The upper bits are ignored.
- R10: Without a preceding START, clocked bytes get no acknowledge and cause no write. `sda_oe` changes only while SCL is low.
- R11: `reg_we` is never high for two system clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 5 | Register array address (the pointer) |
| reg_wdata | output | 8 | Write data for the register array |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data, valid one clock after `reg_addr` |

## Verification
The bench builds the block with its defaults: the 1101111 identifier, a five-bit pointer and two synchronizer stages. With a five-bit pointer, the 0x1F to 0x00 wrap is reached within a few bytes of both a burst write and a sequential read. Address bytes with the upper three bits set show that those bits are dropped. The SCL half period is six system clocks, just above the three-to-four clock synchronizer and edge latency. That margin keeps acknowledge release and data launch inside each low phase.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_WAIT
   } rp_state_e;

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_rp_cond.sv
module i2c_rp_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = !scl_q && scl_s;
   assign scl_fall = scl_q && !scl_s;
   // data edges only count as conditions while the clock stays high
   assign start_ev = scl_q && scl_s && sda_q && !sda_s;
   assign stop_ev  = scl_q && scl_s && !sda_q && sda_s;

endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] ptr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (inc)  ptr <= ptr + 1'b1;   // natural wrap at 2**ADDR_W
   end

endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
   import i2c_rp_pkg::*;
#(
   parameter logic [6:0] DEV_ID      = 7'b1101111,
   parameter int         ADDR_W      = 5,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_we,
   input  logic [7:0]        reg_rdata
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr_w
      $error("ADDR_W must lie between 1 and 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   i2c_rp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2c_rp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2c_rp_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   rp_state_e        state;
   logic [CNT_W-1:0] bit_cnt;
   logic [7:0]       rx_sh;
   logic [7:0]       tx_sh;
   logic             dir_rd;
   logic             m_ack;

   logic byte_done;
   logic ptr_load, ptr_inc;

   assign byte_done = scl_fall && (bit_cnt == LAST_BIT);
   assign ptr_load  = !start_ev && !stop_ev && (state == ST_ADDR) && byte_done;
   assign ptr_inc   = reg_we ||
                      (!start_ev && !stop_ev && (state == ST_RDATA) && byte_done);

   i2c_rp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(ptr_load), .load_val(rx_sh[ADDR_W-1:0]),
      .inc(ptr_inc), .ptr(reg_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         dir_rd    <= 1'b0;
         m_ack     <= 1'b0;
         sda_oe    <= 1'b0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         if (stop_ev) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_ev) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
         end else begin
            unique case (state)
               ST_DEV, ST_ADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     rx_sh   <= {rx_sh[6:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_done) begin
                     bit_cnt <= '0;
                     if (state == ST_DEV) begin
                        if (rx_sh[7:1] == DEV_ID) begin
                           dir_rd <= rx_sh[0];
                           sda_oe <= 1'b1;
                           state  <= ST_DEV_ACK;
                        end else begin
                           state  <= ST_WAIT;
                        end
                     end else if (state == ST_ADDR) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ADDR_ACK;
                     end else begin
                        sda_oe    <= 1'b1;
                        reg_we    <= 1'b1;
                        reg_wdata <= rx_sh;
                        state     <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (dir_rd) begin
                        tx_sh  <= reg_rdata;
                        sda_oe <= !reg_rdata[7];
                        state  <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_ADDR;
                     end
                  end
               end
               ST_ADDR_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_done) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RACK;
                  end else if (scl_fall && bit_cnt != '0) begin
                     tx_sh  <= {tx_sh[6:0], 1'b0};
                     sda_oe <= !tx_sh[6];
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     m_ack <= !sda_s;
                  end else if (scl_fall) begin
                     bit_cnt <= '0;
                     if (m_ack) begin
                        tx_sh  <= reg_rdata;
                        sda_oe <= !reg_rdata[7];
                        state  <= ST_RDATA;
                     end else begin
                        state  <= ST_WAIT;
                     end
                  end
               end
               ST_IDLE, ST_WAIT: begin
                  sda_oe <= 1'b0;
               end
               default: begin
                  state  <= ST_IDLE;
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_regptr_target_chk.sv
module i2c_regptr_target_chk #(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr
);

   // R1: the line is released during and just after reset
   assert_oe_reset_R1: assert property (@(posedge clk) !rst_n |=> !sda_oe);

   // R10: the enable only moves while the bus clock is low
   assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);

   // R11: write strobe lasts one cycle
   assert_we_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R3: each stored byte advances the pointer by one, wrapping
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

   // R2: a write only happens in the low phase after the eighth bit
   assert_we_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !scl_i);

endmodule

bind i2c_regptr_target i2c_regptr_target_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .reg_we(reg_we), .reg_addr(reg_addr));

// File: tb/i2c_regptr_target_bench.sv
module i2c_regptr_target_bench;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;
   localparam logic [7:0] ID_W = 8'hDE;
   localparam logic [7:0] ID_R = 8'hDF;
   localparam int NVEC = 6;
   localparam logic [7:0] VEC_ADDR [NVEC] = '{8'h05, 8'h10, 8'h1F, 8'h00, 8'h0A, 8'h17};
   localparam logic [7:0] VEC_DATA [NVEC] = '{8'h3C, 8'hA5, 8'h81, 8'h7E, 8'h00, 8'hFF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_oe, reg_we;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0] mem [32];
   int wr_cnt;
   logic [4:0] last_waddr;

   logic [7:0] exp_mem [32];
   logic [4:0] exp_ptr;
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   i2c_regptr_target u_i2c_regptr_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata));

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) mem[i] <= 8'h00;
         wr_cnt     <= 0;
         last_waddr <= '0;
         reg_rdata  <= 8'h00;
      end else begin
         if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt        <= wr_cnt + 1;
            last_waddr    <= reg_addr;
         end
         reg_rdata <= mem[reg_addr];
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(Q);
      scl = 1'b1;   wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q);
      scl = 1'b0;   wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(Q);
      scl = 1'b1;   wait_clk(Q);
      sda_m = 1'b1; wait_clk(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_clk(Q);
         scl = 1'b1;   wait_clk(Q);
         scl = 1'b0;   wait_clk(2);
      end
      sda_m = 1'b1; wait_clk(Q);
      scl = 1'b1;   wait_clk(Q/2);
      ack = !sda_bus;
      wait_clk(Q - Q/2);
      scl = 1'b0;   wait_clk(2);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_clk(Q);
         scl = 1'b1; wait_clk(Q/2);
         b[i] = sda_bus;
         wait_clk(Q - Q/2);
         scl = 1'b0;
      end
      wait_clk(Q);
      sda_m = !mack; wait_clk(Q);
      scl = 1'b1;    wait_clk(Q);
      scl = 1'b0;    wait_clk(Q);
      sda_m = 1'b1;
   endtask

   task automatic write_seq(input logic [7:0] addr, input int n,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input string tag);
      bit ack;
      logic [7:0] d;
      bus_start();
      send_byte(ID_W, ack); check({tag, " id ack"}, ack, 1);
      send_byte(addr, ack); check({tag, " addr ack"}, ack, 1);
      exp_ptr = addr[4:0];
      for (int k = 0; k < n; k++) begin
         d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
         send_byte(d, ack); check({tag, " data ack"}, ack, 1);
         exp_mem[exp_ptr] = d;
         exp_ptr = exp_ptr + 1'b1;
      end
      bus_stop();
   endtask

   task automatic read_seq(input bit random, input logic [7:0] addr,
                           input int n, input string tag);
      bit ack;
      logic [7:0] b;
      bus_start();
      if (random) begin
         send_byte(ID_W, ack); check({tag, " dummy id ack"}, ack, 1);
         send_byte(addr, ack); check({tag, " addr ack"}, ack, 1);
         exp_ptr = addr[4:0];
         bus_start();
      end
      send_byte(ID_R, ack); check({tag, " read id ack"}, ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, b);
         check({tag, " read data"}, b, exp_mem[exp_ptr]);
         exp_ptr = exp_ptr + 1'b1;
      end
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      bit ack;
      logic [7:0] b;
      int wc;
      for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
      exp_ptr = '0;

      // R1: reset state, including a START attempt during reset
      wait_clk(3);
      sda_m = 1'b0; wait_clk(Q); sda_m = 1'b1;
      check("R1 oe in reset", sda_oe, 0);
      wait_clk(2);
      rst_n = 1'b1;
      wait_clk(4);
      check("R1 oe after reset", sda_oe, 0);
      check("R1 we after reset", reg_we, 0);
      check("R1 pointer after reset", reg_addr, 0);

      // R2 R5: table of single writes, each read back randomly
      for (int v = 0; v < NVEC; v++) begin
         write_seq(VEC_ADDR[v], 1, VEC_DATA[v], 8'h00, 8'h00, "R2 table");
         check("R2 write address", last_waddr, VEC_ADDR[v][4:0]);
         check("R2 write data", mem[VEC_ADDR[v][4:0]], VEC_DATA[v]);
         read_seq(1'b1, VEC_ADDR[v], 1, "R5 table");
      end

      // R3: burst write across the top of the array
      wc = wr_cnt;
      write_seq(8'h1E, 3, 8'h11, 8'h22, 8'h33, "R3 burst");
      check("R3 write count", wr_cnt - wc, 3);
      check("R3 wrapped store", mem[0], 8'h33);
      check("R3 store 1F", mem[31], 8'h22);

      // R8: current-address read resumes at pointer 0x01
      check("R8 pointer held", reg_addr, 5'h01);
      read_seq(1'b0, 8'h00, 1, "R8 current");

      // R7: after NACK the line stays released through a further byte
      bus_start();
      send_byte(ID_R, ack); check("R7 id ack", ack, 1);
      recv_byte(1'b0, b);
      check("R7 data", b, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 1'b1;
      recv_byte(1'b0, b);
      check("R7 released after nack", b, 8'hFF);
      bus_stop();

      // R6: sequential read across the wrap
      read_seq(1'b1, 8'h1E, 4, "R6 wrap");
      check("R6 pointer after wrap", reg_addr, 5'h02);

      // R4: wrong identifier gets no acknowledge and writes nothing
      wc = wr_cnt;
      bus_start();
      send_byte(8'hA0, ack); check("R4 id nack", ack, 0);
      send_byte(8'h05, ack); check("R4 byte ignored", ack, 0);
      send_byte(8'h99, ack); check("R4 byte ignored 2", ack, 0);
      bus_stop();
      check("R4 no write", wr_cnt - wc, 0);
      read_seq(1'b1, 8'h05, 1, "R4 recovery");

      // R10: bytes without START are ignored
      wc = wr_cnt;
      scl = 1'b0; wait_clk(Q);
      send_byte(ID_W, ack); check("R10 no start id", ack, 0);
      send_byte(8'h03, ack); check("R10 no start addr", ack, 0);
      send_byte(8'h44, ack); check("R10 no start data", ack, 0);
      bus_stop();
      check("R10 no write", wr_cnt - wc, 0);

      // R9: upper address bits dropped
      write_seq(8'hE3, 1, 8'h77, 8'h00, 8'h00, "R9 high addr");
      check("R9 write address", last_waddr, 5'h03);
      read_seq(1'b1, 8'h03, 1, "R9 readback");

      // R11: strobe width seen across a two-byte write
      write_seq(8'h08, 2, 8'h5A, 8'hC3, 8'h00, "R11 burst");
      check("R11 second byte", mem[9], 8'hC3);
      check("R11 strobe idle", reg_we, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule